// File: doc/BRIEF.md
# Mode-Selectable Serial Register Slave

This block gives a host access to a small register file over a slow serial link. It serves either a three-wire bus or a four-wire SPI-style bus. The three-wire bus has an active-low enable, a clock and one shared data line whose direction turns around during reads. The four-wire bus has separate data-in and data-out lines. The bus mode is chosen once, from two mode pins and the serial clock level sampled in the last reset cycle. It stays fixed until the next reset. A third, two-wire addressed mode is recognised but not served: in that mode the block never responds.

Each access starts with an 8-bit control byte that gives the direction and a 7-bit register address. A 16-bit data word follows, written by the host or returned by the slave. The serial enable, clock and data inputs pass through synchronisers into the fast system clock, and an edge detector turns them into single-cycle events. All logic therefore runs in one clock domain. The shared data line is modelled as separate input, output and output-enable pins; the pad logic outside the block combines them.

Top module: `serctl_slave`

## Requirements
- R1: The bus mode is taken from the values present in the last cycle of synchronous reset and is held until the next reset. mode_pins = 2'b10 selects SPI. mode_pins = 2'b01 with sclk high selects two-wire. Every other combination selects three-wire. Pin changes after reset has been released have no effect.
- R2: In two-wire mode the block stays idle: it never enables an output and never writes a register. If mode_pins = 2'b01 is sampled with sclk low, the block runs in three-wire mode instead.
- R3: After sen_n falls, the first 8 bits sampled on sclk rising edges, MSB first, form the control byte. Bit 7 = 1 means read and bit 7 = 0 means write. Bits 6..0 are the register address.
- R4: In a three-wire write, 16 data bits follow the control byte, MSB first. The word is written only on the first sclk rising edge after sen_n has risen. If sen_n falls again before that pulse, nothing is written.
- R5: In a three-wire read, sdio_oe stays low for the half cycle after the 8th rising edge. sdio_oe then rises with the 9th rising edge, which drives data bit 15. Each later rising edge drives the next lower bit, until all 16 bits have been driven.
- R6: In an SPI write, the 16-bit word is written when sen_n rises after all 16 data bits. No extra clock pulse is needed.
- R7: In an SPI read, sdo_oe rises and bit 15 appears on sdo after the falling edge that follows the 8th rising edge. Each later falling edge drives the next lower bit. The host samples on rising edges.
- R8: sdio_oe (three-wire only) and sdo_oe (SPI only) are high only in the data phase of a read. Both drop when sen_n rises or when reset is asserted.
- R9: A transfer in which sen_n rises before the control byte and all 16 data bits have arrived leaves every register unchanged.
- R10: Register addresses at or above NUM_REGS are not implemented. Writes to them are dropped and reads from them return 0.
- R11: Data bits clocked in after the 16th data bit of a write are ignored. The first 16 bits are stored.
- R12: Reset clears every register to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than sclk |
| rst | input | 1 | Synchronous active-high reset; mode is sampled in its last cycle |
| mode_pins | input | 2 | Bus mode strap inputs |
| sen_n | input | 1 | Serial enable, active low |
| sclk | input | 1 | Serial clock from the host |
| sdio_in | input | 1 | Serial data from the host (three-wire data line or SPI data in) |
| sdio_out | output | 1 | Three-wire read data toward the shared line |
| sdio_oe | output | 1 | Drive enable for the shared three-wire data line |
| sdo | output | 1 | SPI read data |
| sdo_oe | output | 1 | Drive enable for the SPI data output |

## Verification
The bench goes after the edge on which read data first appears. A three-wire slave that skipped the turnaround would show sdio_oe at the sample after the 8th rising edge. An SPI slave that shifted on the wrong edge would return its word shifted by one bit. Two write corner cases are also covered: a three-wire write that ends with no final pulse, and a write cut short in the control or data phase. A design that committed on the rise of sen_n, or that counted badly, would change a register that the following read shows as unchanged. Further checks cover pin changes after reset, the two-wire idle mode, addresses beyond the register file and overlong write frames. Each of these would show as a wrong read-back value or as an output enable outside a read window.

// File: rtl/serctl_pkg.sv
package serctl_pkg;

    localparam int SC_DATA_W = 16;
    localparam int SC_ADDR_W = 7;
    localparam int SC_CTRL_W = SC_ADDR_W + 1;

    typedef enum logic [1:0] {
        BUS_3W  = 2'd0,
        BUS_SPI = 2'd1,
        BUS_2W  = 2'd2
    } bus_mode_e;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CTRL,
        ST_WDATA,
        ST_RDATA,
        ST_WAIT
    } frame_st_e;

    typedef struct packed {
        logic                 rd;
        logic [SC_ADDR_W-1:0] addr;
    } ctrl_t;

    typedef struct packed {
        logic                 en;
        logic [SC_ADDR_W-1:0] addr;
        logic [SC_DATA_W-1:0] data;
    } wr_req_t;

    function automatic bus_mode_e pick_mode(input logic [1:0] pins, input logic sck);
        if (pins == 2'b10) return BUS_SPI;
        if (pins == 2'b01 && sck) return BUS_2W;
        return BUS_3W;
    endfunction

endpackage

// File: rtl/serctl_sync.sv
module serctl_sync #(
    parameter int             W       = 3,
    parameter int             STAGES  = 2,
    parameter logic [W-1:0]   RST_VAL = '0
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q,
    output logic [W-1:0] rise,
    output logic [W-1:0] fall
);
    logic [W-1:0] pipe [STAGES];
    logic [W-1:0] prev;

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int s = 0; s < STAGES; s++) pipe[s] <= RST_VAL;
            prev <= RST_VAL;
        end else begin
            pipe[0] <= d;
            for (int s = 1; s < STAGES; s++) pipe[s] <= pipe[s-1];
            prev <= pipe[STAGES-1];
        end
    end

    assign q    = pipe[STAGES-1];
    assign rise = q & ~prev;
    assign fall = ~q & prev;
endmodule

// File: rtl/serctl_regfile.sv
module serctl_regfile
    import serctl_pkg::*;
#(
    parameter int NUM_REGS = 8
) (
    input  logic                 clk,
    input  logic                 rst,
    input  wr_req_t              wr,
    input  logic [SC_ADDR_W-1:0] rd_addr,
    output logic [SC_DATA_W-1:0] rd_data
);
    logic [SC_DATA_W-1:0] mem [NUM_REGS];

    generate
        for (genvar g = 0; g < NUM_REGS; g++) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) mem[g] <= '0;
                else if (wr.en && wr.addr == SC_ADDR_W'(g)) mem[g] <= wr.data;
            end
        end
    endgenerate

    always_comb begin
        rd_data = '0;
        for (int i = 0; i < NUM_REGS; i++)
            if (rd_addr == SC_ADDR_W'(i)) rd_data = mem[i];
    end
endmodule

// File: rtl/serctl_frame.sv
module serctl_frame
    import serctl_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic [1:0]           mode_pins,
    input  logic                 sclk_raw,
    input  logic                 sen_s,
    input  logic                 sck_rise,
    input  logic                 sck_fall,
    input  logic                 sdi_s,
    input  logic [SC_DATA_W-1:0] rd_data,
    output logic [SC_ADDR_W-1:0] acc_addr,
    output wr_req_t              wr,
    output bus_mode_e            mode,
    output logic                 shift_bit,
    output logic                 oe_q
);
    localparam int MAXB  = (SC_DATA_W > SC_CTRL_W) ? SC_DATA_W : SC_CTRL_W;
    localparam int CNT_W = $clog2(MAXB + 1);

    frame_st_e            state;
    logic [CNT_W-1:0]     cnt;
    logic [SC_CTRL_W-1:0] ctrl_sr;
    logic [SC_DATA_W-1:0] data_sr;
    logic [SC_DATA_W-1:0] out_sr;
    logic                 pend;
    logic                 wr_en;
    logic                 drv_edge;
    logic                 data_full;
    ctrl_t                ctrl;

    assign ctrl      = ctrl_t'(ctrl_sr);
    assign acc_addr  = ctrl.addr;
    assign drv_edge  = (mode == BUS_SPI) ? sck_fall : sck_rise;
    assign data_full = (cnt == CNT_W'(SC_DATA_W));
    assign shift_bit = out_sr[SC_DATA_W-1];
    assign wr        = '{en: wr_en, addr: ctrl.addr, data: data_sr};

    always_ff @(posedge clk) begin
        if (rst) mode <= pick_mode(mode_pins, sclk_raw);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            state   <= ST_IDLE;
            cnt     <= '0;
            ctrl_sr <= '0;
            data_sr <= '0;
            out_sr  <= '0;
            pend    <= 1'b0;
            wr_en   <= 1'b0;
            oe_q    <= 1'b0;
        end else begin
            wr_en <= 1'b0;
            unique case (state)
                ST_IDLE: begin
                    if (mode != BUS_2W && !sen_s) begin
                        state <= ST_CTRL;
                        cnt   <= '0;
                        pend  <= 1'b0;
                    end
                end
                ST_CTRL: begin
                    if (sen_s) state <= ST_IDLE;
                    else if (sck_rise) begin
                        ctrl_sr <= {ctrl_sr[SC_CTRL_W-2:0], sdi_s};
                        if (cnt == CNT_W'(SC_CTRL_W - 1)) begin
                            cnt   <= '0;
                            state <= ctrl_sr[SC_CTRL_W-2] ? ST_RDATA : ST_WDATA;
                        end else begin
                            cnt <= cnt + 1'b1;
                        end
                    end
                end
                ST_WDATA: begin
                    if (sen_s) begin
                        if (mode == BUS_SPI) begin
                            wr_en <= data_full;
                            state <= ST_IDLE;
                        end else begin
                            pend  <= data_full;
                            state <= ST_WAIT;
                        end
                    end else if (sck_rise && !data_full) begin
                        data_sr <= {data_sr[SC_DATA_W-2:0], sdi_s};
                        cnt     <= cnt + 1'b1;
                    end
                end
                ST_RDATA: begin
                    if (sen_s) begin
                        oe_q  <= 1'b0;
                        pend  <= 1'b0;
                        state <= (mode == BUS_SPI) ? ST_IDLE : ST_WAIT;
                    end else if (drv_edge && !data_full) begin
                        if (cnt == '0) begin
                            oe_q   <= 1'b1;
                            out_sr <= rd_data;
                        end else begin
                            out_sr <= {out_sr[SC_DATA_W-2:0], 1'b0};
                        end
                        cnt <= cnt + 1'b1;
                    end
                end
                ST_WAIT: begin
                    if (!sen_s) state <= ST_IDLE;
                    else if (sck_rise) begin
                        wr_en <= pend;
                        state <= ST_IDLE;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/serctl_slave.sv
module serctl_slave
    import serctl_pkg::*;
#(
    parameter int NUM_REGS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] mode_pins,
    input  logic       sen_n,
    input  logic       sclk,
    input  logic       sdio_in,
    output logic       sdio_out,
    output logic       sdio_oe,
    output logic       sdo,
    output logic       sdo_oe
);
    logic [2:0]           sync_q, sync_rise, sync_fall;
    logic                 sen_s, sck_rise, sck_fall, sdi_s;
    logic [SC_ADDR_W-1:0] acc_addr;
    logic [SC_DATA_W-1:0] rd_data;
    wr_req_t              wr;
    bus_mode_e            mode;
    logic                 shift_bit;
    logic                 oe_q;
    logic                 wr_en;

    serctl_sync #(.W(3), .STAGES(SYNC_STAGES), .RST_VAL(3'b001)) u_sync (
        .clk(clk), .rst(rst), .d({sdio_in, sclk, sen_n}),
        .q(sync_q), .rise(sync_rise), .fall(sync_fall)
    );

    assign sen_s    = sync_q[0];
    assign sck_rise = sync_rise[1];
    assign sck_fall = sync_fall[1];
    assign sdi_s    = sync_q[2];

    serctl_frame u_frame (
        .clk(clk), .rst(rst), .mode_pins(mode_pins), .sclk_raw(sclk),
        .sen_s(sen_s), .sck_rise(sck_rise), .sck_fall(sck_fall), .sdi_s(sdi_s),
        .rd_data(rd_data), .acc_addr(acc_addr), .wr(wr), .mode(mode),
        .shift_bit(shift_bit), .oe_q(oe_q)
    );

    serctl_regfile #(.NUM_REGS(NUM_REGS)) u_regs (
        .clk(clk), .rst(rst), .wr(wr), .rd_addr(acc_addr), .rd_data(rd_data)
    );

    assign wr_en    = wr.en;
    assign sdio_out = shift_bit;
    assign sdo      = shift_bit;
    assign sdio_oe  = oe_q && (mode == BUS_3W);
    assign sdo_oe   = oe_q && (mode == BUS_SPI);
endmodule

// File: rtl/serctl_slave_chk.sv
module serctl_slave_chk
    import serctl_pkg::*;
(
    input logic      clk,
    input logic      rst,
    input bus_mode_e mode,
    input logic      sen_s,
    input logic      sck_rise,
    input logic      sck_fall,
    input logic      wr_en,
    input logic      sdio_oe,
    input logic      sdo_oe,
    input logic      shift_bit
);
    p_mode_hold_r1: assert property (@(posedge clk) disable iff (rst)
        !$past(rst) |-> $stable(mode));

    p_twowire_quiet_r2: assert property (@(posedge clk) disable iff (rst)
        (mode == BUS_2W) |-> (!wr_en && !sdio_oe && !sdo_oe));

    p_turnaround_r5: assert property (@(posedge clk) disable iff (rst)
        $rose(sdio_oe) |-> $past(sck_rise));

    p_shift_on_rise_r5: assert property (@(posedge clk) disable iff (rst)
        (sdio_oe && $past(sdio_oe) && !$past(sck_rise)) |-> $stable(shift_bit));

    p_spi_drive_fall_r7: assert property (@(posedge clk) disable iff (rst)
        $rose(sdo_oe) |-> $past(sck_fall));

    p_release_on_sen_r8: assert property (@(posedge clk) disable iff (rst)
        sen_s |=> (!sdio_oe && !sdo_oe));

    p_commit_sen_high_r9: assert property (@(posedge clk) disable iff (rst)
        wr_en |-> $past(sen_s));
endmodule

bind serctl_slave serctl_slave_chk u_chk (
    .clk(clk), .rst(rst), .mode(mode), .sen_s(sen_s), .sck_rise(sck_rise),
    .sck_fall(sck_fall), .wr_en(wr_en), .sdio_oe(sdio_oe), .sdo_oe(sdo_oe),
    .shift_bit(shift_bit)
);

// File: tb/tb_serctl_slave.sv
module tb_serctl_slave;
    timeunit 1ns;
    timeprecision 1ps;

    localparam int H    = 8;
    localparam int NREG = 8;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic [1:0] pins = 2'b00;
    logic       sen_n = 1'b1;
    logic       sclk = 1'b0;
    logic       sdio_in = 1'b0;
    logic       sdio_out, sdio_oe, sdo, sdo_oe;

    int checks = 0;
    int fails = 0;
    int bad_oe = 0;
    bit win = 1'b0;
    bit cur3w = 1'b1;
    logic [15:0] model [NREG];

    always #2.5 clk = ~clk;

    serctl_slave #(.NUM_REGS(NREG)) dut (
        .clk(clk), .rst(rst), .mode_pins(pins), .sen_n(sen_n), .sclk(sclk),
        .sdio_in(sdio_in), .sdio_out(sdio_out), .sdio_oe(sdio_oe),
        .sdo(sdo), .sdo_oe(sdo_oe)
    );

    // R8 / R2 monitor: enables only inside a read window of the right mode
    always @(negedge clk) begin
        if (!rst) begin
            if (sdio_oe && !(win && cur3w)) bad_oe++;
            if (sdo_oe && !(win && !cur3w)) bad_oe++;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic hw();
        repeat (H) @(negedge clk);
    endtask

    function automatic logic [15:0] exp_rd(input int a);
        return (a < NREG) ? model[a] : 16'h0;
    endfunction

    task automatic do_reset(input logic [1:0] p, input logic sck);
        @(negedge clk);
        rst = 1'b1; pins = p; sclk = sck; sen_n = 1'b1;
        repeat (4) @(negedge clk);
        rst = 1'b0;
        repeat (4) @(negedge clk);
        pins = ~p;        // R1: later pin changes must not matter
        sclk = 1'b0;
        hw();
        for (int i = 0; i < NREG; i++) model[i] = 16'h0;
    endtask

    task automatic send_bits(input int n, input logic [31:0] v);
        for (int i = n - 1; i >= 0; i--) begin
            sdio_in = v[i];
            hw(); sclk = 1'b1; hw(); sclk = 1'b0;
        end
    endtask

    task automatic final_pulse();
        sclk = 1'b1; hw(); sclk = 1'b0; hw();
    endtask

    // write frame: nd data bits (first min(nd,16) are the word's top bits)
    task automatic wr_frame(input bit m3, input int a, input logic [15:0] d, input int nd, input bit pulse);
        sen_n = 1'b0; hw();
        send_bits(8, {24'h0, 1'b0, 7'(a)});
        if (nd >= 16) begin
            send_bits(16, {16'h0, d});
            if (nd > 16) send_bits(nd - 16, 32'hFFFF_FFFF);
        end else if (nd > 0) begin
            send_bits(nd, 32'(d >> (16 - nd)));
        end
        sen_n = 1'b1; hw();
        if (m3 && pulse) final_pulse();
        hw();
        if (nd >= 16 && (!m3 || pulse) && a < NREG) model[a] = d;
    endtask

    task automatic rd_frame(input bit m3, input int a, output logic [15:0] r);
        r = '0;
        sen_n = 1'b0; hw();
        send_bits(8, {24'h0, 1'b1, 7'(a)});
        win = 1'b1;
        if (m3) begin
            hw();
            chk(!sdio_oe, "R5 turnaround", 32'(sdio_oe), 32'd0);
            for (int k = 0; k < 16; k++) begin
                sclk = 1'b1; hw();
                if (k == 0) chk(sdio_oe, "R5 drive on 9th rise", 32'(sdio_oe), 32'd1);
                r[15-k] = sdio_out;
                sclk = 1'b0; hw();
            end
        end else begin
            for (int k = 0; k < 16; k++) begin
                hw();
                if (k == 0) chk(sdo_oe, "R7 drive after fall", 32'(sdo_oe), 32'd1);
                r[15-k] = sdo;
                sclk = 1'b1; hw(); sclk = 1'b0;
            end
        end
        sen_n = 1'b1; hw();
        chk(!sdio_oe && !sdo_oe, "R8 release on sen rise", {sdio_oe, sdo_oe}, 32'd0);
        win = 1'b0;
        if (m3) final_pulse();
        hw();
    endtask

    task automatic rd_check(input bit m3, input int a, input string req);
        logic [15:0] r;
        rd_frame(m3, a, r);
        chk(r == exp_rd(a), req, 32'(r), 32'(exp_rd(a)));
    endtask

    task automatic random_phase(input bit m3, input int n);
        for (int i = 0; i < n; i++) begin
            int a = int'($urandom % 12);
            logic [15:0] d = 16'($urandom);
            if ($urandom % 3 != 0) wr_frame(m3, a, d, 16, 1'b1);
            rd_check(m3, int'($urandom % 12), m3 ? "R3 R4 R5 random" : "R3 R6 R7 random");
        end
    endtask

    initial begin
        void'($urandom(32'h5EED_0042));
        for (int i = 0; i < NREG; i++) model[i] = 16'h0;

        // three-wire mode (pins 00)
        cur3w = 1'b1;
        do_reset(2'b00, 1'b0);
        for (int a = 0; a < NREG; a++) rd_check(1'b1, a, "R12 reset value");
        wr_frame(1'b1, 3, 16'hA5C3, 16, 1'b1);
        rd_check(1'b1, 3, "R4 three-wire write");
        wr_frame(1'b1, 3, 16'h1234, 16, 1'b0);   // no final pulse
        rd_check(1'b1, 3, "R4 no final pulse keeps old");
        wr_frame(1'b1, 5, 16'hFFFF, 10, 1'b1);   // truncated data
        rd_check(1'b1, 5, "R9 truncated three-wire");
        sen_n = 1'b0; hw(); send_bits(4, 32'h0); sen_n = 1'b1; hw(); final_pulse();
        rd_check(1'b1, 0, "R9 truncated control");
        wr_frame(1'b1, 9, 16'hBEEF, 16, 1'b1);   // beyond register file
        rd_check(1'b1, 9, "R10 high address reads zero");
        rd_check(1'b1, 1, "R10 high write no alias");
        wr_frame(1'b1, 6, 16'h8001, 20, 1'b1);   // overlong
        rd_check(1'b1, 6, "R11 extra bits ignored");
        random_phase(1'b1, 20);

        // SPI mode (pins 10), pins flipped after release
        cur3w = 1'b0;
        do_reset(2'b10, 1'b0);
        rd_check(1'b0, 2, "R1 R12 spi reset value");
        wr_frame(1'b0, 2, 16'h5A0F, 16, 1'b0);
        rd_check(1'b0, 2, "R6 spi write no pulse");
        wr_frame(1'b0, 4, 16'hFFFF, 15, 1'b0);
        rd_check(1'b0, 4, "R9 truncated spi");
        wr_frame(1'b0, 7, 16'h0F0F, 18, 1'b0);
        rd_check(1'b0, 7, "R11 spi extra bits");
        wr_frame(1'b0, 127, 16'h7777, 16, 1'b0);
        rd_check(1'b0, 127, "R10 spi high address");
        random_phase(1'b0, 20);

        // two-wire mode: must stay silent
        cur3w = 1'b1;
        do_reset(2'b01, 1'b1);
        sen_n = 1'b0; hw();
        send_bits(8, 32'h81); send_bits(16, 32'h0);
        chk(!sdio_oe && !sdo_oe, "R2 two-wire idle", {sdio_oe, sdo_oe}, 32'd0);
        sen_n = 1'b1; hw(); final_pulse();

        // same pins with sclk low fall back to three-wire
        do_reset(2'b01, 1'b0);
        wr_frame(1'b1, 1, 16'hC0DE, 16, 1'b1);
        rd_check(1'b1, 1, "R2 fallback three-wire");

        // R8: no enable outside read windows over the whole run
        chk(bad_oe == 0, "R8 enable outside read window", 32'(bad_oe), 32'd0);

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog: actual=%0d expected=%0d", 190000, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule